// File: doc/BRIEF.md
# Multi-Latency Issue Interlock

This block sits at the issue point of an in-order pipeline whose execute stage has four kinds of functional unit with different latencies. The integer unit takes one cycle. The multiplier takes seven cycles and is pipelined. The floating-point adder takes four cycles and is also pipelined. The divider takes twenty-four cycles and is not pipelined. Each cycle the block receives at most one decoded instruction: its unit class, whether it writes a floating-point register, its destination and up to two sources. It then says whether that instruction issues now or must be held.

The register file holds sixteen double-precision registers. Architecturally they are named with even numbers only, F0 through F30, and here they are addressed by a 4-bit index, so index i means F(2i). Index 0 is an ordinary register and is tracked like the rest.

For each register the block keeps a countdown of the cycles left before its newest pending write lands. A reservation shift register books the single write-back port cycle by cycle, and each booking carries its destination tag. A counter tracks divider occupancy. The datapaths themselves are absent: the block only emits a write-back event (a valid bit and a register index) in the cycle each result would be written.

Top module: `fp_issue_interlock`

## Requirements
- R1: After reset no write is pending, the divider is free and no write-back slot is booked. In the first cycle after reset `wb_valid` and `div_busy` are low, and any valid instruction issues.
- R2: Unit codes are 0 integer (latency 1), 1 multiply (7), 2 add (4) and 3 divide (24). An instruction that issues in cycle t with write enable raises `wb_valid` with `wb_reg` equal to its destination in cycle t+latency, and in no other cycle.
- R3: An instruction whose enabled source has a pending write landing after the current cycle is stalled. It may issue in the write-back cycle itself.
- R4: A writing instruction issues only if its latency is strictly greater than the cycles remaining on the pending write to its destination. Otherwise it stalls.
- R5: A writing instruction stalls if its write-back cycle is already booked by an earlier instruction.
- R6: A divide issued in cycle t keeps `div_busy` high in cycles t+1 through t+23. Any divide presented in those cycles stalls; the next divide may issue in cycle t+24.
- R7: Multiply and add operations with no conflicts issue on consecutive cycles.
- R8: While an instruction is stalled, `issue` is low, `stall` is high, and all pending countdowns and bookings keep advancing.
- R9: Register index 0 (F0) is hazard-checked like any other register.
- R10: With `in_valid` low, `issue` and `stall` are low, and the other input fields book nothing and occupy nothing.
- R11: An instruction with write enable low ignores its destination for the R4 and R5 checks and books no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_unit | input | 2 | Unit class: 0 integer, 1 multiply, 2 add, 3 divide |
| in_wr | input | 1 | Instruction writes a floating-point register |
| in_dst | input | 4 | Destination register index |
| in_src_a_en | input | 1 | Source A is read |
| in_src_a | input | 4 | Source A register index |
| in_src_b_en | input | 1 | Source B is read |
| in_src_b | input | 4 | Source B register index |
| issue | output | 1 | Instruction issues this cycle |
| stall | output | 1 | Instruction is held this cycle |
| wb_valid | output | 1 | A result is written back this cycle |
| wb_reg | output | 4 | Register written back this cycle |
| div_busy | output | 1 | Divider occupied by an earlier divide |

## Verification
The assertions check three things on every cycle: an issued instruction never reads a register with a pending write, it never books an occupied write-back slot, and an integer result lands in the very next cycle. They also check that the divider counter falls by one each busy cycle and that a destination countdown is loaded to its latency on issue.

Other properties need a sequence of instructions, and only the bench's scenarios show them. These are the exact write-back cycles of each unit, the release of a RAW stall in the write-back cycle, WAW ordering between add and multiply, a one-cycle port collision, and the 24-cycle divide gap. The scenarios also cover the idle and no-write cases that must leave no trace, which the bench shows by a follow-up instruction that issues at once.

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock #(
  parameter int NREG    = 16,
  parameter int LAT_INT = 1,
  parameter int LAT_MUL = 7,
  parameter int LAT_ADD = 4,
  parameter int LAT_DIV = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              in_unit,
  input  logic                    in_wr,
  input  logic [$clog2(NREG)-1:0] in_dst,
  input  logic                    in_src_a_en,
  input  logic [$clog2(NREG)-1:0] in_src_a,
  input  logic                    in_src_b_en,
  input  logic [$clog2(NREG)-1:0] in_src_b,
  output logic                    issue,
  output logic                    stall,
  output logic                    wb_valid,
  output logic [$clog2(NREG)-1:0] wb_reg,
  output logic                    div_busy
);

  localparam int RW   = $clog2(NREG);
  localparam int LM1  = (LAT_INT > LAT_MUL) ? LAT_INT : LAT_MUL;
  localparam int LM2  = (LAT_ADD > LAT_DIV) ? LAT_ADD : LAT_DIV;
  localparam int LMAX = (LM1 > LM2) ? LM1 : LM2;
  localparam int CW   = $clog2(LMAX + 1);

  localparam logic [1:0] U_INT = 2'd0;
  localparam logic [1:0] U_MUL = 2'd1;
  localparam logic [1:0] U_ADD = 2'd2;
  localparam logic [1:0] U_DIV = 2'd3;

  logic [CW-1:0] pend [NREG];
  logic [LMAX:0] slot_v;
  logic [RW-1:0] slot_r [LMAX+1];
  logic [CW-1:0] div_cnt;
  logic [CW-1:0] lat;
  logic          raw_hz, waw_hz, port_hz, div_hz, hazard;

  always_comb begin
    case (in_unit)
      U_INT:   lat = CW'(LAT_INT);
      U_MUL:   lat = CW'(LAT_MUL);
      U_ADD:   lat = CW'(LAT_ADD);
      default: lat = CW'(LAT_DIV);
    endcase
  end

  assign raw_hz  = (in_src_a_en && pend[in_src_a] != '0) ||
                   (in_src_b_en && pend[in_src_b] != '0);
  assign waw_hz  = in_wr && !(lat > pend[in_dst]);
  assign port_hz = in_wr && slot_v[lat];
  assign div_hz  = (in_unit == U_DIV) && (div_cnt != '0);
  assign hazard  = raw_hz || waw_hz || port_hz || div_hz;

  assign issue    = in_valid && !hazard;
  assign stall    = in_valid && hazard;
  assign wb_valid = slot_v[0];
  assign wb_reg   = slot_r[0];
  assign div_busy = div_cnt != '0;

  for (genvar r = 0; r < NREG; r++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend[r] <= '0;
      else if (issue && in_wr && in_dst == RW'(r))
        pend[r] <= lat - CW'(1);
      else if (pend[r] != '0)
        pend[r] <= pend[r] - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v <= '0;
      for (int k = 0; k <= LMAX; k++) slot_r[k] <= '0;
    end else begin
      for (int k = 0; k < LMAX; k++) begin
        slot_v[k] <= slot_v[k+1];
        slot_r[k] <= slot_r[k+1];
      end
      slot_v[LMAX] <= 1'b0;
      slot_r[LMAX] <= '0;
      if (issue && in_wr) begin
        slot_v[lat - CW'(1)] <= 1'b1;
        slot_r[lat - CW'(1)] <= in_dst;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      div_cnt <= '0;
    else if (issue && in_unit == U_DIV)
      div_cnt <= CW'(LAT_DIV - 1);
    else if (div_cnt != '0)
      div_cnt <= div_cnt - CW'(1);
  end

  a_r3_raw_src_a: assert property (@(posedge clk) disable iff (!rst_n)
    issue && in_src_a_en |-> pend[in_src_a] == '0);

  a_r3_raw_src_b: assert property (@(posedge clk) disable iff (!rst_n)
    issue && in_src_b_en |-> pend[in_src_b] == '0);

  a_r5_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    issue && in_wr |-> !slot_v[lat]);

  a_r2_int_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    issue && in_wr && in_unit == U_INT |=> wb_valid && wb_reg == $past(in_dst));

  a_r4_pend_load: assert property (@(posedge clk) disable iff (!rst_n)
    issue && in_wr |=> pend[$past(in_dst)] == $past(lat) - CW'(1));

  a_r6_div_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |=> div_cnt == $past(div_cnt) - CW'(1));

endmodule

// File: tb/fp_issue_interlock_test.sv
module fp_issue_interlock_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_unit = 2'd0;
  logic       in_wr = 1'b0;
  logic [3:0] in_dst = 4'd0;
  logic       in_src_a_en = 1'b0;
  logic [3:0] in_src_a = 4'd0;
  logic       in_src_b_en = 1'b0;
  logic [3:0] in_src_b = 4'd0;
  logic       issue, stall, wb_valid, div_busy;
  logic [3:0] wb_reg;

  always #2 clk = ~clk;

  fp_issue_interlock uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit), .in_wr(in_wr),
    .in_dst(in_dst), .in_src_a_en(in_src_a_en), .in_src_a(in_src_a),
    .in_src_b_en(in_src_b_en), .in_src_b(in_src_b), .issue(issue), .stall(stall),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .div_busy(div_busy));

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int cyc = 0;
  int last_wb [16];
  int booked [int];
  int last_div = -1000;

  function automatic int lat_of(input int u);
    case (u)
      0: return 1;
      1: return 7;
      2: return 4;
      default: return 24;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit v, input int u, input bit wr, input int dst,
                      input bit sae, input int sa, input bit sbe, input int sb,
                      output bit issued);
    int  lat, pd;
    bit  haz, exp_issue, exp_wb, exp_busy;
    @(negedge clk);
    in_valid = v; in_unit = 2'(u); in_wr = wr; in_dst = 4'(dst);
    in_src_a_en = sae; in_src_a = 4'(sa); in_src_b_en = sbe; in_src_b = 4'(sb);
    #1;
    lat = lat_of(u);
    haz = 0;
    if (sae && last_wb[sa] > cyc) haz = 1;
    if (sbe && last_wb[sb] > cyc) haz = 1;
    if (wr) begin
      pd = last_wb[dst] - cyc;
      if (pd < 0) pd = 0;
      if (!(lat > pd)) haz = 1;
      if (booked.exists(cyc + lat)) haz = 1;
    end
    if (u == 3 && cyc < last_div + 24) haz = 1;
    exp_issue = v && !haz;
    exp_wb    = booked.exists(cyc);
    exp_busy  = (cyc > last_div) && (cyc < last_div + 24);
    check(tag, int'(issue), int'(exp_issue), "issue");
    check(tag, int'(stall), int'(v && haz), "stall");
    check(tag, int'(wb_valid), int'(exp_wb), "wb_valid");
    if (exp_wb) check(tag, int'(wb_reg), booked[cyc], "wb_reg");
    check(tag, int'(div_busy), int'(exp_busy), "div_busy");
    if (exp_issue) begin
      if (wr) begin
        last_wb[dst] = cyc + lat;
        booked[cyc + lat] = dst;
      end
      if (u == 3) last_div = cyc;
    end
    issued = exp_issue;
    cyc++;
  endtask

  task automatic idle(input string tag, input int n);
    bit ok;
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0, 0, 0, ok);
  endtask

  task automatic send(input string tag, input int u, input bit wr, input int dst,
                      input bit sae, input int sa, input bit sbe, input int sb,
                      output int waited);
    bit ok;
    waited = 0;
    for (int i = 0; i < 80; i++) begin
      step(tag, 1, u, wr, dst, sae, sa, sbe, sb, ok);
      if (ok) break;
      waited++;
    end
  endtask

  initial begin
    int w;
    bit ok;
    for (int r = 0; r < 16; r++) last_wb[r] = -1000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, then an integer op issues at once
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, ok);
    send("R1", 0, 1, 1, 1, 2, 1, 3, w);
    check("R1", w, 0, "first issue wait");
    idle("R2", 2);

    // R2: each unit writes back after its latency
    send("R2", 1, 1, 3, 0, 0, 0, 0, w);
    idle("R2", 8);
    send("R2", 2, 1, 4, 0, 0, 0, 0, w);
    idle("R2", 5);
    send("R2", 3, 1, 5, 0, 0, 0, 0, w);
    idle("R2", 25);

    // R7: back-to-back pipelined ops
    send("R7", 1, 1, 1, 0, 0, 0, 0, w); check("R7", w, 0, "mul wait");
    send("R7", 1, 1, 2, 0, 0, 0, 0, w); check("R7", w, 0, "mul wait");
    send("R7", 1, 1, 6, 0, 0, 0, 0, w); check("R7", w, 0, "mul wait");
    idle("R7", 8);
    send("R7", 2, 1, 6, 0, 0, 0, 0, w); check("R7", w, 0, "add wait");
    send("R7", 2, 1, 7, 0, 0, 0, 0, w); check("R7", w, 0, "add wait");
    idle("R7", 5);

    // R3, R8: consumer of a multiply waits until its write-back cycle
    send("R3", 1, 1, 8, 0, 0, 0, 0, w);
    send("R8", 2, 1, 2, 1, 8, 0, 0, w);
    check("R3", w, 6, "raw stall cycles");
    idle("R3", 5);

    // R4: integer write to a register pending a divide stalls; mul over add is allowed
    send("R4", 3, 1, 9, 0, 0, 0, 0, w);
    send("R4", 0, 1, 9, 0, 0, 0, 0, w);
    check("R4", w, 23, "waw stall cycles");
    idle("R4", 3);
    send("R4", 2, 1, 10, 0, 0, 0, 0, w);
    send("R4", 1, 1, 10, 0, 0, 0, 0, w);
    check("R4", w, 0, "longer waw issues");
    idle("R4", 8);

    // R5: write-port collision costs one cycle
    send("R5", 1, 1, 11, 0, 0, 0, 0, w);
    idle("R5", 2);
    send("R5", 2, 1, 12, 0, 0, 0, 0, w);
    check("R5", w, 1, "port stall cycles");
    idle("R5", 8);

    // R6: second divide waits for the first to leave
    send("R6", 3, 1, 13, 0, 0, 0, 0, w);
    send("R6", 3, 1, 14, 0, 0, 0, 0, w);
    check("R6", w, 23, "divide gap");
    idle("R6", 25);

    // R9: F0 is tracked
    send("R9", 1, 1, 0, 0, 0, 0, 0, w);
    send("R9", 2, 1, 5, 1, 0, 1, 0, w);
    check("R9", w, 6, "F0 raw stall cycles");
    idle("R9", 5);

    // R10: idle slot carrying divide fields books nothing
    step("R10", 0, 3, 1, 15, 0, 0, 0, 0, ok);
    send("R10", 3, 1, 1, 0, 0, 0, 0, w);
    check("R10", w, 0, "divide after idle");
    send("R10", 0, 1, 15, 0, 0, 0, 0, w);
    check("R10", w, 0, "slot after idle free");
    idle("R10", 25);

    // R11: non-writing op ignores destination and port
    send("R11", 1, 1, 15, 0, 0, 0, 0, w);
    idle("R11", 2);
    send("R11", 2, 0, 15, 1, 3, 0, 0, w);
    check("R11", w, 0, "no-write issue");
    idle("R11", 10);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule